// File: doc/BRIEF.md
# Pushbuffer Command Stream Decoder

This block sits behind a fetch unit that reads 32-bit command words out of a command buffer. Every list begins with a length in words. The block decodes each header word it receives and expands the argument words that follow into single register-write transactions. Each transaction carries a 13-bit method address, a 3-bit subchannel and a 32-bit value. The length counts header words as well as argument words. The block stops taking words once that many have been consumed.

A header chooses how the method address moves from one argument to the next. It can advance by one per argument, stay fixed, or advance exactly once after the first argument. A fourth mode carries a 13-bit immediate value inside the header itself. Reserved modes, an increment-once header with no arguments, and a list that ends in the middle of an argument run each raise a one-cycle error pulse with a code. Writes leave through a valid/ready port. Input words are taken only while that port is not stalled.

Top module: `pbuf_cmd_decoder`

## Requirements
- R1: A header word is split as mode = bits 31:29, count/immediate = bits 28:16, subchannel = bits 15:13, method = bits 12:0. Every write caused by that header carries its subchannel.
- R2: Modes 0 and 1 (incrementing) write argument i (counting from 0) to method + i.
- R3: Modes 2 and 3 (fixed) write every argument to the header's method.
- R4: Mode 5 (increment-once) writes the first argument to the method and every later argument to method + 1. If the count is 0, err_code 2 is pulsed and no write is issued.
- R5: Mode 4 (immediate) consumes no argument words. It issues one write whose value is the 13-bit count field zero-extended to 32 bits.
- R6: Modes 6 and 7 pulse err_code 1 and issue no write.
- R7: A count of 0 in modes 0 to 3 issues no write and no error, and the next word is decoded as a header.
- R8: list_go with list_len loads a list only while list_active is low. After exactly list_len accepted words, list_active drops. No word is accepted (in_ready low) while list_active is low.
- R9: While wr_valid is high and wr_ready is low, in_ready is low and the write payload holds steady.
- R10: If the list runs out while argument words are still owed, err_code 3 is pulsed and the decoder returns to header decoding. When the header itself is the last word and its count is non-zero, no write is issued.
- R11: Method arithmetic wraps modulo 2^13.
- R12: After reset, wr_valid, err_valid, list_active and in_ready are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| list_go | input | 1 | Load a new list length (taken only while idle) |
| list_len | input | LEN_W | Words in the list, headers included |
| list_active | output | 1 | Words of the current list remain |
| in_valid | input | 1 | Command word offered |
| in_word | input | 32 | Command word |
| in_ready | output | 1 | Command word taken this cycle |
| wr_valid | output | 1 | Register write pending |
| wr_ready | input | 1 | Consumer takes the write |
| wr_method | output | 13 | Method address of the write |
| wr_subch | output | 3 | Subchannel of the write |
| wr_value | output | 32 | Value of the write |
| err_valid | output | 1 | One-cycle error pulse |
| err_code | output | 2 | 1 reserved mode, 2 empty increment-once, 3 truncated list |

## Verification
The bench builds the block with the default LEN_W of 16. The header layout is fixed, so the full 13-bit method range is reachable, and a run that starts at 0x1FFE shows the wrap of the method address. Short lists of one to four words are enough to cover every mode, every error code and a truncated argument run. A stall held over several cycles with wr_ready low checks that the payload stays steady and that input is blocked.

// File: rtl/pbuf_pkg.sv
// Shared types for the command stream decoder.
// Assumes a fixed 32-bit header layout: mode[31:29] count[28:16] subch[15:13] method[12:0].
package pbuf_pkg;
    localparam int WORD_W = 32;
    localparam int MTHD_W = 13;
    localparam int SUB_W  = 3;
    localparam int CNT_W  = 13;

    typedef enum logic [2:0] {
        MODE_INC_A  = 3'd0,
        MODE_INC_B  = 3'd1,
        MODE_FIX_A  = 3'd2,
        MODE_FIX_B  = 3'd3,
        MODE_IMM    = 3'd4,
        MODE_ONCE   = 3'd5,
        MODE_RSV_A  = 3'd6,
        MODE_RSV_B  = 3'd7
    } step_mode_e;

    typedef enum logic [1:0] {
        ERR_NONE       = 2'd0,
        ERR_BAD_MODE   = 2'd1,
        ERR_EMPTY_ONCE = 2'd2,
        ERR_TRUNC      = 2'd3
    } err_code_e;

    typedef struct packed {
        step_mode_e          mode;
        logic [CNT_W-1:0]    cnt;
        logic [SUB_W-1:0]    sub;
        logic [MTHD_W-1:0]   mthd;
    } hdr_t;

    typedef enum logic {ST_HDR = 1'b0, ST_ARG = 1'b1} dec_state_e;
endpackage

// File: rtl/pbuf_hdr_decode.sv
// Header field splitter and classifier (R1).
// Purely combinational; assumes its input is a header word, and the caller decides when it is one.
module pbuf_hdr_decode
    import pbuf_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output step_mode_e        mode,
    output logic [CNT_W-1:0]  cnt,
    output logic [SUB_W-1:0]  sub,
    output logic [MTHD_W-1:0] mthd,
    output logic              is_bad,
    output logic              is_imm,
    output logic              is_empty
);
    hdr_t h;

    // Split the word into its header fields.
    always_comb begin
        h    = hdr_t'(word);
        mode = h.mode;
        cnt  = h.cnt;
        sub  = h.sub;
        mthd = h.mthd;
    end

    // Classify the mode and the count.
    always_comb begin
        is_bad   = (h.mode == MODE_RSV_A) || (h.mode == MODE_RSV_B);
        is_imm   = (h.mode == MODE_IMM);
        is_empty = (h.cnt == '0);
    end
endmodule

// File: rtl/pbuf_addr_step.sv
// Method address generator for argument words (R2, R3, R4, R11).
// Combinational; idx is the zero-based argument index, and sums wrap at the method width.
module pbuf_addr_step
    import pbuf_pkg::*;
(
    input  logic [MTHD_W-1:0] base,
    input  step_mode_e        mode,
    input  logic [CNT_W-1:0]  idx,
    output logic [MTHD_W-1:0] mthd
);
    localparam int IDX_PAD = (MTHD_W > CNT_W) ? MTHD_W - CNT_W : 0;

    logic [MTHD_W-1:0] idx_m;

    // Resize the argument index to the method width.
    always_comb begin
        idx_m = MTHD_W'({{IDX_PAD{1'b0}}, idx});
    end

    // Choose the stepping rule for the mode.
    always_comb begin
        unique case (mode)
            MODE_INC_A, MODE_INC_B: mthd = base + idx_m;
            MODE_ONCE:              mthd = (idx == '0) ? base : base + MTHD_W'(1);
            default:                mthd = base;
        endcase
    end
endmodule

// File: rtl/pbuf_wr_reg.sv
// Output register for register-write transactions, valid/ready (R9).
// Assumes load is raised only when the register is empty or is being drained this cycle.
module pbuf_wr_reg
    import pbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [MTHD_W-1:0] ld_mthd,
    input  logic [SUB_W-1:0]  ld_sub,
    input  logic [WORD_W-1:0] ld_val,
    input  logic              ready,
    output logic              valid,
    output logic [MTHD_W-1:0] mthd,
    output logic [SUB_W-1:0]  sub,
    output logic [WORD_W-1:0] val,
    output logic              stall
);
    // Signal that a pending write is being held back.
    always_comb begin
        stall = valid && !ready;
    end

    // Hold, load or drain the pending write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            mthd  <= '0;
            sub   <= '0;
            val   <= '0;
        end else if (load) begin
            valid <= 1'b1;
            mthd  <= ld_mthd;
            sub   <= ld_sub;
            val   <= ld_val;
        end else if (ready) begin
            valid <= 1'b0;
        end
    end

    assert_payload_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(mthd) && $stable(sub) && $stable(val)));

    assert_no_load_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !load);
endmodule

// File: rtl/pbuf_cmd_decoder.sv
// Command stream decoder top: counts list words, walks header/argument states,
// issues register writes and pulses error codes.
// Assumes the fetch side presents words in list order and drives list_go only between lists.
module pbuf_cmd_decoder
    import pbuf_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              list_go,
    input  logic [LEN_W-1:0]  list_len,
    output logic              list_active,
    input  logic              in_valid,
    input  logic [31:0]       in_word,
    output logic              in_ready,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [12:0]       wr_method,
    output logic [2:0]        wr_subch,
    output logic [31:0]       wr_value,
    output logic              err_valid,
    output logic [1:0]        err_code
);
    localparam int IMM_PAD = WORD_W - CNT_W;

    logic [LEN_W-1:0]  remain_q;
    dec_state_e        state_q, state_d;
    step_mode_e        cur_mode_q;
    logic [MTHD_W-1:0] cur_mthd_q;
    logic [SUB_W-1:0]  cur_sub_q;
    logic [CNT_W-1:0]  args_left_q;
    logic [CNT_W-1:0]  arg_idx_q;

    step_mode_e        d_mode;
    logic [CNT_W-1:0]  d_cnt;
    logic [SUB_W-1:0]  d_sub;
    logic [MTHD_W-1:0] d_mthd;
    logic              d_bad, d_imm, d_empty;

    logic [MTHD_W-1:0] step_mthd;
    logic              out_stall;
    logic              acc, last_word, start_list;
    logic              wr_load;
    logic [MTHD_W-1:0] ld_mthd;
    logic [SUB_W-1:0]  ld_sub;
    logic [WORD_W-1:0] ld_val;
    logic              err_fire;
    err_code_e         err_sel;
    logic              hdr_take;

    pbuf_hdr_decode u_hdr (
        .word     (in_word),
        .mode     (d_mode),
        .cnt      (d_cnt),
        .sub      (d_sub),
        .mthd     (d_mthd),
        .is_bad   (d_bad),
        .is_imm   (d_imm),
        .is_empty (d_empty)
    );

    pbuf_addr_step u_step (
        .base (cur_mthd_q),
        .mode (cur_mode_q),
        .idx  (arg_idx_q),
        .mthd (step_mthd)
    );

    pbuf_wr_reg u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (wr_load),
        .ld_mthd (ld_mthd),
        .ld_sub  (ld_sub),
        .ld_val  (ld_val),
        .ready   (wr_ready),
        .valid   (wr_valid),
        .mthd    (wr_method),
        .sub     (wr_subch),
        .val     (wr_value),
        .stall   (out_stall)
    );

    // Handshake and list bookkeeping terms.
    always_comb begin
        list_active = (remain_q != '0);
        in_ready    = list_active && !out_stall;
        acc         = in_valid && in_ready;
        last_word   = (remain_q == LEN_W'(1));
        start_list  = list_go && !list_active;
    end

    // Decide the write, the error and the next state for an accepted word.
    always_comb begin
        wr_load  = 1'b0;
        ld_mthd  = step_mthd;
        ld_sub   = cur_sub_q;
        ld_val   = in_word;
        err_fire = 1'b0;
        err_sel  = ERR_NONE;
        state_d  = state_q;
        hdr_take = 1'b0;
        if (acc) begin
            if (state_q == ST_HDR) begin
                if (d_bad) begin
                    err_fire = 1'b1;
                    err_sel  = ERR_BAD_MODE;
                end else if (d_imm) begin
                    wr_load = 1'b1;
                    ld_mthd = d_mthd;
                    ld_sub  = d_sub;
                    ld_val  = {{IMM_PAD{1'b0}}, d_cnt};
                end else if (d_empty) begin
                    if (d_mode == MODE_ONCE) begin
                        err_fire = 1'b1;
                        err_sel  = ERR_EMPTY_ONCE;
                    end
                end else if (last_word) begin
                    err_fire = 1'b1;
                    err_sel  = ERR_TRUNC;
                end else begin
                    hdr_take = 1'b1;
                    state_d  = ST_ARG;
                end
            end else begin
                wr_load = 1'b1;
                if (args_left_q == CNT_W'(1)) begin
                    state_d = ST_HDR;
                end else if (last_word) begin
                    err_fire = 1'b1;
                    err_sel  = ERR_TRUNC;
                    state_d  = ST_HDR;
                end
            end
        end
    end

    // Remaining-word counter for the current list.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (start_list) begin
            remain_q <= list_len;
        end else if (acc) begin
            remain_q <= remain_q - LEN_W'(1);
        end
    end

    // Decoder state and captured header context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_HDR;
            cur_mode_q  <= MODE_INC_A;
            cur_mthd_q  <= '0;
            cur_sub_q   <= '0;
            args_left_q <= '0;
            arg_idx_q   <= '0;
        end else if (start_list) begin
            state_q <= ST_HDR;
        end else begin
            state_q <= state_d;
            if (hdr_take) begin
                cur_mode_q  <= d_mode;
                cur_mthd_q  <= d_mthd;
                cur_sub_q   <= d_sub;
                args_left_q <= d_cnt;
                arg_idx_q   <= '0;
            end else if (acc && state_q == ST_ARG) begin
                args_left_q <= args_left_q - CNT_W'(1);
                arg_idx_q   <= arg_idx_q + CNT_W'(1);
            end
        end
    end

    // One-cycle error pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_valid <= 1'b0;
            err_code  <= ERR_NONE;
        end else begin
            err_valid <= err_fire;
            err_code  <= err_sel;
        end
    end

    assert_err_from_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> $past(in_valid && in_ready));

    assert_hdr_err_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && (err_code == ERR_BAD_MODE || err_code == ERR_EMPTY_ONCE))
            |-> (wr_valid == $past(wr_valid && !wr_ready)));

    assert_list_end_on_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(list_active) |-> $past(in_valid && in_ready));

    assert_write_from_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_valid) |-> $past(in_valid && in_ready));

    assert_once_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && state_q == ST_ARG && cur_mode_q == MODE_ONCE && arg_idx_q != '0)
            |-> (step_mthd == cur_mthd_q + MTHD_W'(1)));

    assert_trunc_to_hdr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && err_code == ERR_TRUNC) |-> (state_q == ST_HDR && !list_active));
endmodule

// File: tb/pbuf_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module pbuf_cmd_decoder_tb_top;
    localparam int LEN_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic list_go = 1'b0;
    logic [LEN_W-1:0] list_len = '0;
    logic list_active;
    logic in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic in_ready;
    logic wr_valid;
    logic wr_ready = 1'b1;
    logic [12:0] wr_method;
    logic [2:0] wr_subch;
    logic [31:0] wr_value;
    logic err_valid;
    logic [1:0] err_code;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    logic [12:0] got_m [16];
    logic [2:0]  got_s [16];
    logic [31:0] got_v [16];
    int n_wr = 0;
    logic [1:0] got_e [16];
    int n_err = 0;

    always #2.5 clk = ~clk;

    pbuf_cmd_decoder #(.LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .list_go(list_go), .list_len(list_len),
        .list_active(list_active), .in_valid(in_valid), .in_word(in_word),
        .in_ready(in_ready), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_method(wr_method), .wr_subch(wr_subch), .wr_value(wr_value),
        .err_valid(err_valid), .err_code(err_code)
    );

    function automatic logic [31:0] hdr(input logic [2:0] md, input logic [12:0] c,
                                        input logic [2:0] s, input logic [12:0] m);
        return {md, c, s, m};
    endfunction

    typedef struct packed {
        logic [31:0] w0;
        logic [31:0] w1;
        logic [1:0]  len;
        logic [1:0]  nwr;
        logic [12:0] m;
        logic [2:0]  s;
        logic [31:0] v;
        logic [1:0]  err;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{w0: hdr(3'd1, 13'd1, 3'd2, 13'h010), w1: 32'hDEADBEEF, len: 2'd2, nwr: 2'd1, m: 13'h010, s: 3'd2, v: 32'hDEADBEEF, err: 2'd0},
        '{w0: hdr(3'd0, 13'd1, 3'd7, 13'h1F0), w1: 32'h12345678, len: 2'd2, nwr: 2'd1, m: 13'h1F0, s: 3'd7, v: 32'h12345678, err: 2'd0},
        '{w0: hdr(3'd3, 13'd1, 3'd1, 13'h044), w1: 32'hCAFEF00D, len: 2'd2, nwr: 2'd1, m: 13'h044, s: 3'd1, v: 32'hCAFEF00D, err: 2'd0},
        '{w0: hdr(3'd4, 13'h1ABC, 3'd5, 13'h123), w1: 32'h0, len: 2'd1, nwr: 2'd1, m: 13'h123, s: 3'd5, v: 32'h00001ABC, err: 2'd0},
        '{w0: hdr(3'd6, 13'd1, 3'd0, 13'h001), w1: 32'h0, len: 2'd1, nwr: 2'd0, m: 13'h0, s: 3'd0, v: 32'h0, err: 2'd1},
        '{w0: hdr(3'd7, 13'd2, 3'd3, 13'h002), w1: 32'h0, len: 2'd1, nwr: 2'd0, m: 13'h0, s: 3'd0, v: 32'h0, err: 2'd1},
        '{w0: hdr(3'd5, 13'd0, 3'd4, 13'h055), w1: 32'h0, len: 2'd1, nwr: 2'd0, m: 13'h0, s: 3'd0, v: 32'h0, err: 2'd2},
        '{w0: hdr(3'd1, 13'd1, 3'd0, 13'h060), w1: 32'h0, len: 2'd1, nwr: 2'd0, m: 13'h0, s: 3'd0, v: 32'h0, err: 2'd3}
    };
    localparam string VTAG [NVEC] = '{"R2", "R2", "R3", "R5", "R6", "R6", "R4", "R10"};

    // Capture transfers and error pulses well away from the clock edges.
    always begin
        @(negedge clk);
        #1.5;
        if (wr_valid && wr_ready && n_wr < 16) begin
            got_m[n_wr] = wr_method;
            got_s[n_wr] = wr_subch;
            got_v[n_wr] = wr_value;
            n_wr++;
        end
        if (err_valid && n_err < 16) begin
            got_e[n_err] = err_code;
            n_err++;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clear_cap();
        n_wr = 0;
        n_err = 0;
    endtask

    task automatic start_list(input int len);
        @(negedge clk);
        list_go = 1'b1;
        list_len = LEN_W'(len);
        @(posedge clk);
        #0.5;
        list_go = 1'b0;
    endtask

    task automatic push(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_word = w;
        #0.5;
        while (!in_ready) begin
            @(negedge clk);
            #0.5;
        end
        @(posedge clk);
        #0.5;
        in_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (3) @(negedge clk);
        #2.0;
    endtask

    task automatic chk_wr(input int k, input logic [12:0] m, input logic [2:0] s,
                          input logic [31:0] v, input string tag);
        chk(got_m[k] == m, {tag, " method"}, 32'(got_m[k]), 32'(m));
        chk(got_s[k] == s, {tag, " subch"}, 32'(got_s[k]), 32'(s));
        chk(got_v[k] == v, {tag, " value"}, got_v[k], v);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #0.5;
        rst_n = 1'b1;
        @(negedge clk);
        #2.0;
        // R12 reset state
        chk(!wr_valid, "R12 wr_valid", 32'(wr_valid), 0);
        chk(!err_valid, "R12 err_valid", 32'(err_valid), 0);
        chk(!list_active, "R12 list_active", 32'(list_active), 0);
        chk(!in_ready, "R12 in_ready", 32'(in_ready), 0);

        // Table of single-header lists
        for (int i = 0; i < NVEC; i++) begin
            clear_cap();
            start_list(int'(VECS[i].len));
            push(VECS[i].w0);
            if (VECS[i].len == 2'd2) push(VECS[i].w1);
            drain();
            chk(n_wr == int'(VECS[i].nwr), {VTAG[i], " write count"}, 32'(n_wr), 32'(VECS[i].nwr));
            if (VECS[i].nwr != 2'd0 && n_wr > 0) chk_wr(0, VECS[i].m, VECS[i].s, VECS[i].v, VTAG[i]);
            chk(n_err == (VECS[i].err != 2'd0 ? 1 : 0), {VTAG[i], " error count"}, 32'(n_err), 32'(VECS[i].err != 2'd0));
            if (VECS[i].err != 2'd0 && n_err > 0)
                chk(got_e[0] == VECS[i].err, {VTAG[i], " error code"}, 32'(got_e[0]), 32'(VECS[i].err));
            chk(!list_active, {VTAG[i], " list end R8"}, 32'(list_active), 0);
        end

        // R2 and R11: incrementing run across the method wrap
        clear_cap();
        start_list(4);
        push(hdr(3'd1, 13'd3, 3'd3, 13'h1FFE));
        push(32'h11); push(32'h22); push(32'h33);
        drain();
        chk(n_wr == 3, "R2 run count", 32'(n_wr), 3);
        chk_wr(0, 13'h1FFE, 3'd3, 32'h11, "R2 arg0");
        chk_wr(1, 13'h1FFF, 3'd3, 32'h22, "R2 arg1");
        chk_wr(2, 13'h0000, 3'd3, 32'h33, "R11 wrap");

        // R3: fixed method
        clear_cap();
        start_list(4);
        push(hdr(3'd2, 13'd3, 3'd6, 13'h100));
        push(32'hA1); push(32'hA2); push(32'hA3);
        drain();
        chk(n_wr == 3, "R3 run count", 32'(n_wr), 3);
        for (int k = 0; k < 3; k++) chk_wr(k, 13'h100, 3'd6, 32'hA1 + 32'(k), "R3 fixed");

        // R4: increment-once
        clear_cap();
        start_list(4);
        push(hdr(3'd5, 13'd3, 3'd1, 13'h200));
        push(32'hB1); push(32'hB2); push(32'hB3);
        drain();
        chk(n_wr == 3, "R4 run count", 32'(n_wr), 3);
        chk_wr(0, 13'h200, 3'd1, 32'hB1, "R4 first");
        chk_wr(1, 13'h201, 3'd1, 32'hB2, "R4 second");
        chk_wr(2, 13'h201, 3'd1, 32'hB3, "R4 third");

        // R7: empty count header, then the next word is a header
        clear_cap();
        start_list(2);
        push(hdr(3'd1, 13'd0, 3'd0, 13'h300));
        push(hdr(3'd4, 13'h7, 3'd1, 13'h301));
        drain();
        chk(n_wr == 1, "R7 write count", 32'(n_wr), 1);
        chk_wr(0, 13'h301, 3'd1, 32'h7, "R7 next header");
        chk(n_err == 0, "R7 no error", 32'(n_err), 0);
        chk(!list_active, "R8 two-word list end", 32'(list_active), 0);

        // R10: truncated run, then header decoding resumes
        clear_cap();
        start_list(2);
        push(hdr(3'd0, 13'd3, 3'd2, 13'h400));
        push(32'hC0FFEE);
        drain();
        chk(n_wr == 1, "R10 partial write", 32'(n_wr), 1);
        chk_wr(0, 13'h400, 3'd2, 32'hC0FFEE, "R10 arg");
        chk(n_err == 1 && got_e[0] == 2'd3, "R10 trunc code", 32'(got_e[0]), 3);
        clear_cap();
        start_list(1);
        push(hdr(3'd4, 13'h55, 3'd0, 13'h010));
        drain();
        chk(n_wr == 1 && got_m[0] == 13'h010, "R10 resumes header", 32'(got_m[0]), 32'h010);

        // R9: backpressure holds payload and blocks input
        clear_cap();
        wr_ready = 1'b0;
        start_list(3);
        push(hdr(3'd1, 13'd2, 3'd4, 13'h500));
        push(32'hE1);
        @(negedge clk);
        in_valid = 1'b1;
        in_word = 32'hE2;
        repeat (3) @(negedge clk);
        #0.5;
        chk(!in_ready, "R9 input blocked", 32'(in_ready), 0);
        chk(wr_valid && wr_value == 32'hE1, "R9 payload held", wr_value, 32'hE1);
        wr_ready = 1'b1;
        #0.5;
        chk(in_ready, "R9 released", 32'(in_ready), 1);
        @(posedge clk);
        #0.5;
        in_valid = 1'b0;
        drain();
        chk(n_wr == 2, "R9 write count", 32'(n_wr), 2);
        chk_wr(0, 13'h500, 3'd4, 32'hE1, "R9 first");
        chk_wr(1, 13'h501, 3'd4, 32'hE2, "R9 second");

        // R8: no list loaded, input ignored
        clear_cap();
        @(negedge clk);
        in_valid = 1'b1;
        in_word = hdr(3'd4, 13'h1, 3'd0, 13'h1);
        repeat (4) @(negedge clk);
        #0.5;
        chk(!in_ready, "R8 idle in_ready", 32'(in_ready), 0);
        in_valid = 1'b0;
        drain();
        chk(n_wr == 0, "R8 idle no write", 32'(n_wr), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule